// File: doc/BRIEF.md
# Serial Packet Input Deframer

This block terminates one input lane of a bit-serial packet switch. Each lane is a single data wire with two active-low qualifiers: a frame strobe that stays low for the length of a packet and a valid strobe that marks payload bits. The deframer recovers the destination port number from the packet head and steps over a fixed guard interval. It then rebuilds the payload bits into bytes. Each finished byte goes downstream together with the destination and a flag that says whether it closes the packet.

The lane has three phases. A head of `ADDR_W` bits carries the destination, least significant bit first, and begins in the cycle the frame strobe falls. A guard of `PAD_LEN` cycles follows, with the data wire parked high and the valid strobe high. The payload comes last, one bit per cycle in which the valid strobe is low, least significant bit first. The frame strobe returns high on the last payload bit, so no length field is needed.

A framing violation produces a one-cycle error pulse. After it the block waits for the next falling edge of the frame strobe. Downstream logic samples the byte, the address and the last flag in the cycle the byte strobe is high.

Top module: `pkt_deframer`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `byteValid`, `byteLast` and `protoErr` are 0.
- R2: A packet starts in the cycle `frameN` goes from 1 to 0. That cycle and the following three carry destination bits 0 to 3 on `din`. The assembled value appears on `pktAddr` whenever `byteValid` is 1.
- R3: During the four head cycles the value of `validN` has no effect on any output.
- R4: The five cycles after the head are a guard. `din` is not stored there, and the first payload bit is sampled in the tenth cycle of the packet.
- R5: Payload bits sampled with `validN` = 0 fill a byte from bit 0 upward. In the cycle after the eighth such bit, `byteValid` is 1 for exactly one cycle and `byteData` holds the byte.
- R6: A payload-phase cycle with `validN` = 1 and `frameN` = 0 adds no bit and does not move the bit position.
- R7: When the eighth bit of a byte is sampled in the cycle `frameN` is 1, that byte is delivered with `byteLast` = 1. All other bytes have `byteLast` = 0.
- R8: `validN` = 0 during any guard cycle gives `protoErr` = 1 for one cycle, in the next cycle. The block is then idle, and a `frameN` that is still low does not start a packet.
- R9: `frameN` = 1 during the head, during the guard, or in a payload cycle that is not the eighth bit of a byte gives a one-cycle `protoErr` pulse, and no byte is delivered for that cycle.
- R10: A packet whose `frameN` falls in the cycle right after the previous packet's last bit is received in full, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial data line |
| frameN | input | 1 | Packet frame strobe, active low |
| validN | input | 1 | Payload bit qualifier, active low |
| pktAddr | output | ADDR_W (4) | Destination port of the current packet |
| byteData | output | BYTE_W (8) | Assembled payload byte |
| byteValid | output | 1 | One-cycle pulse per delivered byte |
| byteLast | output | 1 | Marks the final byte of a packet |
| protoErr | output | 1 | One-cycle framing-violation pulse |

## Verification
Two functions can fall in the same clock cycle: completing a byte and ending the packet. Both happen on the cycle `frameN` rises. In addition, the next packet's start can follow that cycle directly. The bench provokes the overlap by ending packets normally, by sending packets back to back, and by raising `frameN` on bit 3 instead of bit 7. A behavioural model built from queues judges each cycle. It must see either a byte with `byteLast` or an error pulse, never both, and the next packet's head must be taken in full.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PAD,
    ST_DATA
  } phase_e;

  // strobes from control to datapath, all valid in the cycle they are raised
  typedef struct packed {
    logic addrShift;
    logic dataShift;
    logic emit;
    logic emitLast;
    logic err;
  } dp_ctl_t;

endpackage

// File: rtl/pkt_deframer_ctrl.sv
module pkt_deframer_ctrl
  import pkt_deframer_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PAD_LEN = 5,
  parameter int BYTE_W  = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameN,
  input  logic     validN,
  output dp_ctl_t  ctl
);
  localparam int CNT_MAX = (ADDR_W > PAD_LEN) ? ADDR_W : PAD_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] PAD_END  = CNT_W'(PAD_LEN - 1);
  localparam logic [BIT_W-1:0] BIT_END  = BIT_W'(BYTE_W - 1);

  phase_e            state, stNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic [BIT_W-1:0]  bitCnt, bitNext;
  logic              frameNPrev;
  logic              frameFall;
  logic              bitDone;

  assign frameFall = frameNPrev && !frameN;
  assign bitDone   = !validN && (bitCnt == BIT_END);

  always_comb begin
    ctl     = '0;
    stNext  = state;
    cntNext = cnt;
    bitNext = bitCnt;
    unique case (state)
      ST_IDLE: begin
        if (frameFall) begin
          ctl.addrShift = 1'b1;
          stNext        = ST_ADDR;
          cntNext       = CNT_W'(1);
        end
      end
      ST_ADDR: begin
        if (frameN) begin
          ctl.err = 1'b1;
          stNext  = ST_IDLE;
        end else begin
          ctl.addrShift = 1'b1;
          if (cnt == ADDR_END) begin
            stNext  = ST_PAD;
            cntNext = '0;
          end else begin
            cntNext = cnt + CNT_W'(1);
          end
        end
      end
      ST_PAD: begin
        if (frameN || !validN) begin
          ctl.err = 1'b1;
          stNext  = ST_IDLE;
        end else if (cnt == PAD_END) begin
          stNext  = ST_DATA;
          cntNext = '0;
          bitNext = '0;
        end else begin
          cntNext = cnt + CNT_W'(1);
        end
      end
      ST_DATA: begin
        if (frameN) begin
          stNext = ST_IDLE;
          if (bitDone) begin
            ctl.dataShift = 1'b1;
            ctl.emit      = 1'b1;
            ctl.emitLast  = 1'b1;
          end else begin
            ctl.err = 1'b1;
          end
        end else if (!validN) begin
          ctl.dataShift = 1'b1;
          if (bitDone) begin
            ctl.emit = 1'b1;
            bitNext  = '0;
          end else begin
            bitNext = bitCnt + BIT_W'(1);
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitCnt     <= '0;
      frameNPrev <= 1'b1;
    end else begin
      state      <= stNext;
      cnt        <= cntNext;
      bitCnt     <= bitNext;
      frameNPrev <= frameN;
    end
  end

  // R10: a falling frame edge seen in idle always opens the head phase
  a_r10_start_head: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && frameNPrev && !frameN) |=> (state == ST_ADDR));

  // R8: guard phase never survives a low valid strobe
  a_r8_pad_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAD && !validN) |=> (state == ST_IDLE));

endmodule

// File: rtl/pkt_deframer_dp.sv
module pkt_deframer_dp
  import pkt_deframer_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              din,
  input  dp_ctl_t           ctl,
  output logic [ADDR_W-1:0] pktAddr,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              byteLast,
  output logic              protoErr
);
  logic [ADDR_W-1:0] addrSh;
  logic [BYTE_W-1:0] dataSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSh    <= '0;
      dataSh    <= '0;
      byteValid <= 1'b0;
      byteLast  <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      byteValid <= ctl.emit;
      byteLast  <= ctl.emitLast;
      protoErr  <= ctl.err;
      if (ctl.addrShift) addrSh <= {din, addrSh[ADDR_W-1:1]};
      if (ctl.dataShift) dataSh <= {din, dataSh[BYTE_W-1:1]};
    end
  end

  // the last shift of a byte leaves it whole in the register until the next valid bit
  assign byteData = dataSh;
  assign pktAddr  = addrSh;

  // R1: strobes are quiet in the first cycle out of reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!byteValid && !protoErr && !byteLast));

  // R7: the last flag never stands without its byte
  a_r7_last_with_byte: assert property (@(posedge clk) disable iff (!rstN)
    byteLast |-> byteValid);

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import pkt_deframer_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PAD_LEN = 5,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              din,
  input  logic              frameN,
  input  logic              validN,
  output logic [ADDR_W-1:0] pktAddr,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteValid,
  output logic              byteLast,
  output logic              protoErr
);
  dp_ctl_t ctl;

  pkt_deframer_ctrl #(
    .ADDR_W (ADDR_W),
    .PAD_LEN(PAD_LEN),
    .BYTE_W (BYTE_W)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .frameN(frameN),
    .validN(validN),
    .ctl   (ctl)
  );

  pkt_deframer_dp #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .din      (din),
    .ctl      (ctl),
    .pktAddr  (pktAddr),
    .byteData (byteData),
    .byteValid(byteValid),
    .byteLast (byteLast),
    .protoErr (protoErr)
  );

  // R5: byte strobe is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R6: a byte only completes on a sample taken with the valid strobe low
  a_r6_bit_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> !$past(validN));

  // R7: the last flag follows a high frame sample
  a_r7_last_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    byteLast |-> $past(frameN));

  // R9: an error cycle never delivers a byte
  a_r9_err_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(byteValid && protoErr));

endmodule

// File: tb/pkt_deframer_tb_top.sv
`timescale 1ns/1ps
module pkt_deframer_tb_top;
  localparam int ADDR_W = 4;
  localparam int PAD_LEN = 5;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic din = 1'b0;
  logic frameN = 1'b1;
  logic validN = 1'b1;
  logic [ADDR_W-1:0] pktAddr;
  logic [BYTE_W-1:0] byteData;
  logic byteValid, byteLast, protoErr;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;
  bit started = 0;
  string curReq = "R1";

  always #2.5 clk = ~clk;

  pkt_deframer #(.ADDR_W(ADDR_W), .PAD_LEN(PAD_LEN), .BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rstN(rstN), .din(din), .frameN(frameN), .validN(validN),
    .pktAddr(pktAddr), .byteData(byteData), .byteValid(byteValid),
    .byteLast(byteLast), .protoErr(protoErr)
  );

  // behavioural reference: phase name, position counter, bit queue
  int mPhase = 0;      // 0 idle, 1 head, 2 guard, 3 payload
  int mPos = 0;
  bit mPrevF = 1;
  int mAddr = 0;
  bit mBits[$];
  bit expV = 0, expE = 0, expL = 0;
  int expD = 0, expA = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mPos = 0; mPrevF = 1; mAddr = 0; mBits.delete();
      expV = 0; expE = 0; expL = 0;
    end else begin
      expV = 0; expE = 0; expL = 0;
      if (mPhase == 0) begin
        if (mPrevF && !frameN) begin
          mAddr = int'(din); mPos = 1; mPhase = 1;
        end
      end else if (mPhase == 1) begin
        if (frameN) begin expE = 1; mPhase = 0; end
        else begin
          mAddr = mAddr | (int'(din) << mPos);
          mPos++;
          if (mPos == ADDR_W) begin mPos = 0; mPhase = 2; end
        end
      end else if (mPhase == 2) begin
        if (frameN || !validN) begin expE = 1; mPhase = 0; end
        else begin
          mPos++;
          if (mPos == PAD_LEN) begin mPhase = 3; mBits.delete(); end
        end
      end else begin
        if (!validN) mBits.push_back(din);
        if (frameN) begin
          if (!validN && mBits.size() == BYTE_W) begin expV = 1; expL = 1; end
          else expE = 1;
          mPhase = 0;
        end else if (mBits.size() == BYTE_W) expV = 1;
        if (expV) begin
          expD = 0;
          for (int k = 0; k < BYTE_W; k++) expD = expD | (int'(mBits[k]) << k);
          expA = mAddr;
          mBits.delete();
        end
      end
      mPrevF = frameN;
    end
    started = 1;
  end

  task automatic cmp(input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cmp("byteValid", int'(byteValid), int'(expV));
      cmp("protoErr", int'(protoErr), int'(expE));
      if (expV) begin
        cmp("byteData", int'(byteData), expD);
        cmp("byteLast", int'(byteLast), int'(expL));
        cmp("pktAddr", int'(pktAddr), expA);
      end else begin
        cmp("byteLast", int'(byteLast), 0);
      end
    end
  end

  task automatic drive(input logic d, input logic f, input logic v);
    @(negedge clk);
    din = d; frameN = f; validN = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b1);
  endtask

  int txBytes[$];

  // errMode: 0 none, 1 valid low in guard, 2 frame high at bit 3, 3 frame high in head
  task automatic sendPkt(input int a, input int gapEvery, input int errMode);
    for (int i = 0; i < ADDR_W; i++) begin
      if (errMode == 3 && i == 2) begin
        drive(1'b0, 1'b1, 1'b1);
        return;
      end
      drive(a[i], 1'b0, 1'($urandom_range(0, 1)));
    end
    for (int i = 0; i < PAD_LEN; i++) begin
      if (errMode == 1 && i == 2) begin
        drive(1'b1, 1'b0, 1'b0);
        for (int j = 0; j < 3; j++) drive(1'($urandom_range(0, 1)), 1'b0, 1'b0);
        return;
      end
      drive(1'b1, 1'b0, 1'b1);
    end
    for (int b = 0; b < txBytes.size(); b++) begin
      for (int i = 0; i < BYTE_W; i++) begin
        if (gapEvery > 0 && (i % gapEvery) == 1) drive(1'($urandom_range(0, 1)), 1'b0, 1'b1);
        if (errMode == 2 && b == 0 && i == 3) begin
          drive(txBytes[b][i], 1'b1, 1'b0);
          return;
        end
        drive(txBytes[b][i], (b == txBytes.size() - 1 && i == BYTE_W - 1) ? 1'b1 : 1'b0, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    curReq = "R1";
    cmp("reset byteValid", int'(byteValid), 0);
    cmp("reset protoErr", int'(protoErr), 0);
    rstN = 1'b1;
    idle(3);

    curReq = "R2";  // also R4, R5, R7 on the same packet
    txBytes.delete(); txBytes.push_back(8'h33); txBytes.push_back(8'h77);
    sendPkt(3, 0, 0); idle(2);

    curReq = "R3";
    txBytes.delete(); txBytes.push_back(8'hA5);
    for (int r = 0; r < 4; r++) begin sendPkt(12 - r, 0, 0); idle(1); end

    curReq = "R6";
    txBytes.delete(); txBytes.push_back(8'h81); txBytes.push_back(8'h3C); txBytes.push_back(8'hFF);
    sendPkt(5, 3, 0); idle(2);

    curReq = "R7";
    txBytes.delete(); txBytes.push_back(8'h00);
    sendPkt(15, 0, 0); idle(2);

    curReq = "R8";
    txBytes.delete(); txBytes.push_back(8'h5A);
    sendPkt(9, 0, 1); idle(2);
    sendPkt(6, 0, 0); idle(2);

    curReq = "R9";
    sendPkt(2, 0, 2); idle(2);
    sendPkt(7, 0, 3); idle(2);
    sendPkt(1, 0, 0); idle(2);

    curReq = "R10";
    txBytes.delete(); txBytes.push_back(8'hC3); txBytes.push_back(8'h1E);
    sendPkt(4, 0, 0);
    txBytes.delete(); txBytes.push_back(8'h96);
    sendPkt(11, 2, 0);
    sendPkt(13, 0, 0);
    idle(4);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule